// File: doc/BRIEF.md
# Transition-Coded Serial Receiver with Zero Removal

This block sits on the receive side of a serial link. The line is sampled once for each cycle on which a bit-enable tick is high. Each sample is compared with the sample taken on the previous tick, and the data bit is recovered from whether the level changed. Only the presence or absence of a change matters, so a line whose polarity was inverted somewhere along the path decodes to the same data.

Two conventions are supported. In space mode a change means 0 and a steady level means 1. In mark mode the mapping is reversed. The transmitter inserts a zero after a fixed run of ones. The receiver removes that zero, and the run length is chosen with a mode input: five ones for frame-delimited (HDLC-style) links, six ones for USB-style links. A removed zero still counts as a level change on the line, but no data is emitted for it. In the five-run mode, a zero that follows six ones is the frame delimiter and is reported as a pulse. A one arriving where an inserted zero was required sets a sticky error flag. Software clears that flag with a clear input.

Top module: `nrzi_destuff_rx`

## Requirements
- R1: During and right after reset, `dout`, `dout_valid`, `delim_det` and `stuff_err` are 0. The held previous level resets to 1, so in space mode a first tick with `line_in`=1 decodes as a 1.
- R2: With `mark_mode`=0 (space), a tick whose sample equals the previous sample yields data 1, and a tick whose sample differs yields data 0. `dout_valid` pulses for one clock, and `dout` holds the bit in the clock after the tick.
- R3: With `mark_mode`=1 (mark), a level change yields data 1 and a steady level yields data 0.
- R4: Inverting every line sample gives the same decoded output on every tick after the first.
- R5: With `usb_mode`=0, a 0 that directly follows exactly 5 consecutive decoded 1s is removed. No `dout_valid` is given for it, and the count of ones restarts at zero.
- R6: With `usb_mode`=1, a 0 that directly follows 6 or more consecutive decoded 1s is removed, with no `dout_valid`.
- R7: With `usb_mode`=0, a 0 that follows 6 or more consecutive decoded 1s gives a one-clock `delim_det` pulse and no `dout_valid`. The ones before it are still emitted as data.
- R8: A decoded 1 that arrives after 6 consecutive 1s sets `stuff_err`. In `usb_mode`=1 this is the 7th one; in `usb_mode`=0 it is the 7th one. The 1 itself is still emitted as data.
- R9: `stuff_err` stays set until `err_clr` is high on a clock edge. If a new violation arrives on that same edge, the flag stays set.
- R10: On clocks without `bit_en`, `dout_valid` and `delim_det` are 0 and the line is not sampled, so the decoding of later ticks is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit tick; the line is sampled on clocks where this is high |
| line_in | input | 1 | Line level |
| usb_mode | input | 1 | 0: insertion after 5 ones with delimiter detection; 1: insertion after 6 ones |
| mark_mode | input | 1 | 0: change means 0; 1: change means 1 |
| err_clr | input | 1 | Clears the sticky error flag |
| dout | output | 1 | Decoded data bit |
| dout_valid | output | 1 | One-clock strobe marking `dout` as a new data bit |
| delim_det | output | 1 | One-clock pulse on a detected frame delimiter |
| stuff_err | output | 1 | Sticky flag for a missing inserted zero |

## Verification
Every result is registered, so it appears exactly one clock after the edge that samples the tick. `stuff_err` reacts to a violation or a clear on that same edge. The bench drives inputs 1 ns after a rising edge and advances its reference model at that moment. It waits for the next rising edge and samples 1 ns later, so each comparison falls in the single clock where the result is due. On idle clocks the bench checks that no strobe appears. It then checks that later ticks decode as if the idle clocks had not occurred.

// File: rtl/nrzi_rx_pkg.sv
package nrzi_rx_pkg;
  typedef enum logic [1:0] {
    EV_DATA  = 2'd0,
    EV_STUFF = 2'd1,
    EV_DELIM = 2'd2
  } bit_event_e;
endpackage

// File: rtl/nrzi_level_tracker.sv
module nrzi_level_tracker (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic line_in,
  input  logic mark_mode,
  output logic dec_bit
);
  logic prev_lvl;
  logic changed;

  assign changed = line_in ^ prev_lvl;
  assign dec_bit = mark_mode ? changed : ~changed;

  always_ff @(posedge clk) begin
    if (rst)         prev_lvl <= 1'b1;
    else if (bit_en) prev_lvl <= line_in;
  end

  // R10: idle clocks leave the held level alone
  p_idle_level_r10: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(prev_lvl));
endmodule

// File: rtl/ones_run_counter.sv
module ones_run_counter #(
  parameter int CNT_MAX = 6,
  parameter int CNT_W   = $clog2(CNT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             dec_bit,
  output logic [CNT_W-1:0] run_cnt
);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
    end else if (bit_en) begin
      if (!dec_bit)           run_cnt <= '0;
      else if (run_cnt != SAT) run_cnt <= run_cnt + 1'b1;
    end
  end

  // R8: the run never exceeds its saturation limit
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (rst)
    run_cnt <= SAT);
  // R10: no tick, no change in the run
  p_cnt_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(run_cnt));
endmodule

// File: rtl/destuff_classifier.sv
module destuff_classifier
  import nrzi_rx_pkg::*;
#(
  parameter int HDLC_RUN = 5,
  parameter int USB_RUN  = 6,
  parameter int CNT_W    = 3
) (
  input  logic             dec_bit,
  input  logic [CNT_W-1:0] run_cnt,
  input  logic             usb_mode,
  output bit_event_e       ev,
  output logic             viol
);
  localparam logic [CNT_W-1:0] T_HDLC = CNT_W'(HDLC_RUN);
  localparam logic [CNT_W-1:0] T_FLAG = CNT_W'(HDLC_RUN + 1);
  localparam logic [CNT_W-1:0] T_USB  = CNT_W'(USB_RUN);

  logic [CNT_W-1:0] thr;
  logic [CNT_W-1:0] err_lim;

  assign thr     = usb_mode ? T_USB : T_HDLC;
  assign err_lim = usb_mode ? T_USB : T_FLAG;

  always_comb begin
    ev   = EV_DATA;
    viol = 1'b0;
    if (dec_bit) begin
      viol = (run_cnt >= err_lim);
    end else if (!usb_mode && run_cnt >= T_FLAG) begin
      ev = EV_DELIM;
    end else if (run_cnt >= thr) begin
      ev = EV_STUFF;
    end
  end
endmodule

// File: rtl/nrzi_destuff_rx.sv
module nrzi_destuff_rx
  import nrzi_rx_pkg::*;
#(
  parameter int HDLC_RUN = 5,
  parameter int USB_RUN  = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic line_in,
  input  logic usb_mode,
  input  logic mark_mode,
  input  logic err_clr,
  output logic dout,
  output logic dout_valid,
  output logic delim_det,
  output logic stuff_err
);
  localparam int CNT_MAX = (USB_RUN > HDLC_RUN + 1) ? USB_RUN : HDLC_RUN + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic             dec_bit;
  logic [CNT_W-1:0] run_cnt;
  bit_event_e       ev;
  logic             viol;

  nrzi_level_tracker u_lvl (
    .clk(clk), .rst(rst), .bit_en(bit_en), .line_in(line_in),
    .mark_mode(mark_mode), .dec_bit(dec_bit)
  );

  ones_run_counter #(.CNT_MAX(CNT_MAX), .CNT_W(CNT_W)) u_run (
    .clk(clk), .rst(rst), .bit_en(bit_en), .dec_bit(dec_bit), .run_cnt(run_cnt)
  );

  destuff_classifier #(.HDLC_RUN(HDLC_RUN), .USB_RUN(USB_RUN), .CNT_W(CNT_W)) u_cls (
    .dec_bit(dec_bit), .run_cnt(run_cnt), .usb_mode(usb_mode), .ev(ev), .viol(viol)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dout       <= 1'b0;
      dout_valid <= 1'b0;
      delim_det  <= 1'b0;
    end else begin
      dout_valid <= 1'b0;
      delim_det  <= 1'b0;
      if (bit_en) begin
        unique case (ev)
          EV_DATA: begin
            dout_valid <= 1'b1;
            dout       <= dec_bit;
          end
          EV_DELIM: delim_det <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 stuff_err <= 1'b0;
    else if (bit_en && viol) stuff_err <= 1'b1;
    else if (err_clr)        stuff_err <= 1'b0;
  end

  // R10: a strobe only follows a tick
  p_valid_tick_r10: assert property (@(posedge clk) disable iff (rst)
    dout_valid |-> $past(bit_en));
  // R7: a delimiter never carries data
  p_delim_excl_r7: assert property (@(posedge clk) disable iff (rst)
    delim_det |-> !dout_valid);
  // R7: delimiters only in the five-run mode
  p_delim_mode_r7: assert property (@(posedge clk) disable iff (rst)
    delim_det |-> !$past(usb_mode));
  // R9: the flag holds without a clear
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (stuff_err && !err_clr) |=> stuff_err);
endmodule

// File: tb/tb_nrzi_destuff_rx.sv
module tb_nrzi_destuff_rx;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0, line_in = 1'b1, usb_mode = 1'b0, mark_mode = 1'b0, err_clr = 1'b0;
  logic dout, dout_valid, delim_det, stuff_err;

  int n_chk = 0, n_bad = 0;
  string cur_req = "R1";

  // bench reference state
  logic m_prev;
  int   m_cnt;
  logic m_err;
  logic e_valid, e_dout, e_delim;

  always #4 clk = ~clk;

  nrzi_destuff_rx dut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .line_in(line_in), .usb_mode(usb_mode),
    .mark_mode(mark_mode), .err_clr(err_clr), .dout(dout), .dout_valid(dout_valid),
    .delim_det(delim_det), .stuff_err(stuff_err)
  );

  task automatic chk(string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", cur_req, what, act, exp);
    end
  endtask

  task automatic model(logic en, logic lvl, logic clr);
    logic t, b;
    int thr;
    e_valid = 1'b0;
    e_delim = 1'b0;
    thr = usb_mode ? 6 : 5;
    if (clr) m_err = 1'b0;
    if (en) begin
      t = lvl ^ m_prev;
      m_prev = lvl;
      b = mark_mode ? t : ~t;
      if (b) begin
        if (m_cnt == 6) m_err = 1'b1;
        if (m_cnt < 6) m_cnt++;
        e_valid = 1'b1;
        e_dout = 1'b1;
      end else begin
        if (!usb_mode && m_cnt == 6) e_delim = 1'b1;
        else if (m_cnt != thr) begin
          e_valid = 1'b1;
          e_dout = 1'b0;
        end
        m_cnt = 0;
      end
    end
  endtask

  // drive just after an edge, compare just after the following edge
  task automatic step(logic en, logic lvl, logic clr);
    bit_en = en; line_in = lvl; err_clr = clr;
    model(en, lvl, clr);
    @(posedge clk); #1;
    chk("dout_valid", dout_valid, e_valid);
    chk("delim_det", delim_det, e_delim);
    chk("stuff_err", stuff_err, m_err);
    if (e_valid) chk("dout", dout, e_dout);
    bit_en = 1'b0; err_clr = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; bit_en = 1'b0; err_clr = 1'b0;
    @(posedge clk); #1;
    @(posedge clk); #1;
    cur_req = "R1";
    chk("reset dout", dout, 1'b0);
    chk("reset dout_valid", dout_valid, 1'b0);
    chk("reset delim_det", delim_det, 1'b0);
    chk("reset stuff_err", stuff_err, 1'b0);
    rst = 1'b0;
    m_prev = 1'b1; m_cnt = 0; m_err = 1'b0;
  endtask

  // line level that gives decoded bit b
  function automatic logic lvl_for(logic b);
    return mark_mode ? (m_prev ^ b) : (m_prev ^ ~b);
  endfunction

  task automatic print_sum();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    print_sum();
    $finish;
  end

  initial begin
    logic [1:0] rec [16];
    logic [15:0] pat;
    void'($urandom(32'd5171));

    // R1: held level starts high, space mode, steady high decodes 1
    usb_mode = 1'b0; mark_mode = 1'b0;
    do_reset();
    cur_req = "R1";
    step(1'b1, 1'b1, 1'b0);
    chk("R1 first bit is one", dout, 1'b1);

    // R2: space mapping, change gives 0
    cur_req = "R2";
    step(1'b1, 1'b0, 1'b0);
    chk("R2 change decodes zero", dout, 1'b0);
    step(1'b1, 1'b0, 1'b0);

    // R3: mark mapping
    do_reset();
    mark_mode = 1'b1;
    cur_req = "R3";
    step(1'b1, 1'b0, 1'b0);
    chk("R3 change decodes one", dout, 1'b1);
    step(1'b1, 1'b0, 1'b0);
    chk("R3 steady decodes zero", dout, 1'b0);

    // R4: polarity independence
    cur_req = "R4";
    mark_mode = 1'b0;
    pat = 16'hB3C5;
    do_reset();
    for (int i = 0; i < 16; i++) begin
      step(1'b1, pat[i], 1'b0);
      rec[i] = {dout_valid, dout};
    end
    do_reset();
    cur_req = "R4";
    for (int i = 0; i < 16; i++) begin
      step(1'b1, ~pat[i], 1'b0);
      if (i > 0) begin
        chk("R4 inverted valid", dout_valid, rec[i][1]);
        chk("R4 inverted data", dout, rec[i][0]);
      end
    end

    // R5 with R10: five ones with idle gaps, then inserted zero dropped
    do_reset();
    usb_mode = 1'b0;
    cur_req = "R5";
    step(1'b1, lvl_for(1'b0), 1'b0);
    for (int i = 0; i < 5; i++) begin
      step(1'b1, lvl_for(1'b1), 1'b0);
      cur_req = "R10";
      step(1'b0, ~line_in, 1'b0);
      chk("R10 idle no strobe", dout_valid, 1'b0);
      cur_req = "R5";
    end
    step(1'b1, lvl_for(1'b0), 1'b0);
    chk("R5 inserted zero dropped", dout_valid, 1'b0);
    step(1'b1, lvl_for(1'b1), 1'b0);
    chk("R5 run restarts", dout, 1'b1);

    // R7: delimiter
    cur_req = "R7";
    step(1'b1, lvl_for(1'b0), 1'b0);
    for (int i = 0; i < 6; i++) step(1'b1, lvl_for(1'b1), 1'b0);
    step(1'b1, lvl_for(1'b0), 1'b0);
    chk("R7 delimiter pulse", delim_det, 1'b1);
    chk("R7 no data on delimiter", dout_valid, 1'b0);
    step(1'b1, lvl_for(1'b0), 1'b0);
    chk("R7 pulse one clock", delim_det, 1'b0);

    // R6, R8, R9 in six-run mode
    do_reset();
    usb_mode = 1'b1;
    cur_req = "R6";
    for (int i = 0; i < 6; i++) step(1'b1, lvl_for(1'b1), 1'b0);
    step(1'b1, lvl_for(1'b0), 1'b0);
    chk("R6 inserted zero dropped", dout_valid, 1'b0);
    cur_req = "R8";
    for (int i = 0; i < 7; i++) step(1'b1, lvl_for(1'b1), 1'b0);
    chk("R8 seventh one flags", stuff_err, 1'b1);
    chk("R8 seventh one still data", dout_valid, 1'b1);
    cur_req = "R9";
    step(1'b1, lvl_for(1'b1), 1'b1);
    chk("R9 set beats clear", stuff_err, 1'b1);
    step(1'b0, line_in, 1'b0);
    chk("R9 held", stuff_err, 1'b1);
    step(1'b0, line_in, 1'b1);
    chk("R9 cleared", stuff_err, 1'b0);

    // R8 in five-run mode: seventh one
    do_reset();
    usb_mode = 1'b0;
    cur_req = "R8";
    for (int i = 0; i < 7; i++) step(1'b1, lvl_for(1'b1), 1'b0);
    chk("R8 five-run mode flags", stuff_err, 1'b1);

    // random traffic
    for (int blk = 0; blk < 6; blk++) begin
      usb_mode = $urandom_range(0, 1);
      mark_mode = $urandom_range(0, 1);
      do_reset();
      cur_req = "rand";
      for (int i = 0; i < 600; i++) begin
        logic en, b, clr;
        en = ($urandom_range(0, 3) != 0);
        b = ($urandom_range(0, 9) < 8);
        clr = ($urandom_range(0, 49) == 0);
        step(en, en ? lvl_for(b) : logic'($urandom_range(0, 1)), clr);
      end
    end

    print_sum();
    $finish;
  end
endmodule